// File: doc/BRIEF.md
# Board Interconnect Test Sequencer

This block is a host-side controller that checks the board wiring between the host and a set of memory devices. It runs after power-up and before any of those devices is initialized. It visits each device in turn. For each one, it uses only that device's chip select plus the shared clock-enable and column-strobe lines to put the device into its static connection-test mode. It then drives a fixed set of stimulus words onto a 20-line input bus and reads the 32-bit data bus back. Each read is compared with the response that a correctly wired device would return. After the last stimulus it takes the device out of test mode and moves on to the next device.

Every stimulus word is compared with its expected response, and each mismatch is reported for one cycle. The report carries the device index, the vector index and a 32-bit difference mask. An open line, a short between lines, an absent device and a misplaced device all show up as a mismatch. When every device has been visited, the sequencer deselects all devices, enables the memory clock and holds a no-operation state for a parameterised pause. It then raises `done`, with `pass` showing whether the whole run was free of mismatches. Only a reset starts a new run.

Top module: `bic_sequencer`

## Requirements
- R1: Out of reset, every chip select is high, clock enable is high, the column strobe is high, the memory clock enable is low, the stimulus bus is zero, and `busy`, `done` and `failValid` are low.
- R2: A `start` pulse while idle visits devices 0 to DEV_CNT-1 in ascending order, and at most one chip select is low at any time.
- R3: Test-mode entry for a device takes two cycles. In the first cycle its chip select is low, clock enable is low and the column strobe is high. In the second cycle the column strobe goes low while clock enable stays low.
- R4: Each device receives 42 stimulus vectors in this order:
  - indices 0 to 19 are walking-one words (`1<<k`);
  - indices 20 to 39 are walking-zero words (`~(1<<(k-20))`);
  - index 40 is all zeros;
  - index 41 is all ones.
- R5: Each vector is held with the device's chip select low, clock enable high and the column strobe low for `accessWait+1` cycles, using the `accessWait` value captured at `start`. The data bus is sampled at the clock edge that ends the last of those cycles.
- R6: Expected response bit j (0..31) equals the XNOR of stimulus bits `j mod 20` and `(j+7) mod 20`.
- R7: A mismatch raises `failValid` for one cycle, starting one cycle after the sampling edge. During that cycle `failDev` and `failVec` give the device and vector, and `failMask` equals the sampled data XOR the expected word. A matching sample produces no report.
- R8: Exit takes one cycle, directly after the device's last vector. In that cycle the chip select is still low, clock enable is low and the column strobe rises.
- R9: After the last device exits, all devices are deselected, clock enable and column strobe are high, and the memory clock enable is high. This state lasts PAUSE_CYC cycles before `done` rises.
- R10: `done` stays high once set. `pass` is high only while `done` is high and no mismatch was reported in the run.
- R11: `start` has no effect while a run is in progress or after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, also the only way to rerun |
| start | input | 1 | Begin a run (honoured only when idle) |
| accessWait | input | WAIT_W | Extra cycles each vector is held before sampling |
| dqIn | input | 32 | Data bus read back from the devices |
| memCsN | output | DEV_CNT | Active-low chip select, one per device |
| memCke | output | 1 | Shared clock-enable line |
| memCasN | output | 1 | Shared column-strobe line used for mode entry and exit |
| testVec | output | 20 | Stimulus word on the address/control lines |
| memClkEn | output | 1 | Memory clock running (pause and after) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |
| pass | output | 1 | Run complete with no mismatch |
| failValid | output | 1 | One-cycle mismatch report |
| failDev | output | DEV_W | Device of the reported mismatch |
| failVec | output | 6 | Vector index of the reported mismatch |
| failMask | output | 32 | Mismatching data bits |

## Verification
The bench models each device as a combinational responder that answers only after it has seen a proper entry. It follows the pins at the falling clock edge. A vector becomes visible in the cycle after the sequencer moves to it. The bench measures how long each vector is held and expects exactly `accessWait+1` cycles, for wait values 0, 1 and 3. A mismatch report is due in the cycle after the sampling edge, so the bench reads `failMask` at that cycle's falling edge. It compares the mask with the difference between the ideal response and the faulted response, both computed from the requirement's formula. The bench also counts the pause cycles between the last exit and `done`, and checks that `done` and the idle pins do not change after extra `start` pulses.

// File: rtl/bic_pkg.sv
package bic_pkg;

  parameter int IN_W     = 20;
  parameter int DQ_W     = 32;
  parameter int PAIR_OFS = 7;
  parameter int NUM_VEC  = 2 * IN_W + 2;
  parameter int VEC_W    = $clog2(NUM_VEC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ENTER, ST_DRIVE, ST_EXIT, ST_PAUSE, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic drive;
    logic sample;
  } seqStrobe_t;

  // stimulus word for a vector index: walking one, walking zero, zeros, ones
  function automatic logic [IN_W-1:0] stimFor(input logic [VEC_W-1:0] idx);
    int unsigned k;
    logic [IN_W-1:0] w;
    k = int'(idx);
    if (k < IN_W)            w = IN_W'(1) << k;
    else if (k < 2 * IN_W)   w = ~(IN_W'(1) << (k - IN_W));
    else if (k == 2 * IN_W)  w = '0;
    else                     w = '1;
    return w;
  endfunction

  // response a correctly wired device returns for a stimulus word
  function automatic logic [DQ_W-1:0] respFor(input logic [IN_W-1:0] s);
    logic [DQ_W-1:0] r;
    for (int j = 0; j < DQ_W; j++)
      r[j] = ~(s[j % IN_W] ^ s[(j + PAIR_OFS) % IN_W]);
    return r;
  endfunction

endpackage

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int DEV_CNT   = 2,
  parameter int WAIT_W    = 8,
  parameter int PAUSE_CYC = 20000,
  parameter int DEV_W     = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WAIT_W-1:0]  accessWait,
  output logic [DEV_CNT-1:0] memCsN,
  output logic               memCke,
  output logic               memCasN,
  output logic               memClkEn,
  output logic               busy,
  output logic               done,
  output seqStrobe_t         strobe,
  output logic [DEV_W-1:0]   devIdx,
  output logic [VEC_W-1:0]   vecIdx
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);

  seqState_t          state;
  logic [WAIT_W-1:0]  waitCnt;
  logic [WAIT_W-1:0]  waitLim;
  logic [PAUSE_W-1:0] pauseCnt;
  logic               devSel;
  logic               lastVec;
  logic               lastDev;

  assign lastVec = (vecIdx == VEC_W'(NUM_VEC - 1));
  assign lastDev = (devIdx == DEV_W'(DEV_CNT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      devIdx   <= '0;
      vecIdx   <= '0;
      waitCnt  <= '0;
      waitLim  <= '0;
      pauseCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SETUP;
          devIdx  <= '0;
          waitLim <= accessWait;
        end
        ST_SETUP: state <= ST_ENTER;
        ST_ENTER: begin
          state   <= ST_DRIVE;
          vecIdx  <= '0;
          waitCnt <= '0;
        end
        ST_DRIVE: begin
          if (waitCnt == waitLim) begin
            waitCnt <= '0;
            if (lastVec) state <= ST_EXIT;
            else         vecIdx <= VEC_W'(vecIdx + 1'b1);
          end else begin
            waitCnt <= WAIT_W'(waitCnt + 1'b1);
          end
        end
        ST_EXIT: begin
          if (lastDev) begin
            state    <= ST_PAUSE;
            pauseCnt <= '0;
          end else begin
            state  <= ST_SETUP;
            devIdx <= DEV_W'(devIdx + 1'b1);
          end
        end
        ST_PAUSE: begin
          if (pauseCnt == PAUSE_W'(PAUSE_CYC - 1)) state <= ST_DONE;
          else pauseCnt <= PAUSE_W'(pauseCnt + 1'b1);
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign devSel = (state == ST_SETUP) || (state == ST_ENTER) ||
                  (state == ST_DRIVE) || (state == ST_EXIT);

  for (genvar d = 0; d < DEV_CNT; d++) begin : g_cs
    assign memCsN[d] = !(devSel && (devIdx == DEV_W'(d)));
  end

  assign memCke   = !((state == ST_SETUP) || (state == ST_ENTER) || (state == ST_EXIT));
  assign memCasN  = !((state == ST_ENTER) || (state == ST_DRIVE));
  assign memClkEn = (state == ST_PAUSE) || (state == ST_DONE);
  assign done     = (state == ST_DONE);
  assign busy     = (state != ST_IDLE) && (state != ST_DONE);

  assign strobe.clear  = (state == ST_IDLE) && start;
  assign strobe.drive  = (state == ST_DRIVE);
  assign strobe.sample = (state == ST_DRIVE) && (waitCnt == waitLim);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~memCsN) <= 1); // R2
  AST_ENTRY_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCasN) |-> (!memCke && $stable(memCsN))); // R3
  AST_EXIT_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCasN) |-> (!memCke && $stable(memCsN))); // R8
  AST_CLK_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    memClkEn |-> (&memCsN && memCke && memCasN)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R10

endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter int DEV_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DEV_W-1:0] devIdx,
  input  logic [VEC_W-1:0] vecIdx,
  input  logic [DQ_W-1:0]  dqIn,
  output logic [IN_W-1:0]  testVec,
  output logic             failValid,
  output logic [DEV_W-1:0] failDev,
  output logic [VEC_W-1:0] failVec,
  output logic [DQ_W-1:0]  failMask,
  output logic             anyFail
);

  logic [IN_W-1:0] stimWord;
  logic [DQ_W-1:0] expWord;
  logic [DQ_W-1:0] diffWord;

  assign stimWord = stimFor(vecIdx);
  assign expWord  = respFor(stimWord);
  assign diffWord = dqIn ^ expWord;
  assign testVec  = strobe.drive ? stimWord : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failValid <= 1'b0;
      failDev   <= '0;
      failVec   <= '0;
      failMask  <= '0;
      anyFail   <= 1'b0;
    end else begin
      failValid <= 1'b0;
      if (strobe.clear) anyFail <= 1'b0;
      if (strobe.sample && (|diffWord)) begin
        failValid <= 1'b1;
        failDev   <= devIdx;
        failVec   <= vecIdx;
        failMask  <= diffWord;
        anyFail   <= 1'b1;
      end
    end
  end

  AST_REPORT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    failValid |-> $past(strobe.sample)); // R7

endmodule

// File: rtl/bic_sequencer.sv
module bic_sequencer
  import bic_pkg::*;
#(
  parameter int DEV_CNT   = 2,
  parameter int WAIT_W    = 8,
  parameter int PAUSE_CYC = 20000,
  localparam int DEV_W    = (DEV_CNT > 1) ? $clog2(DEV_CNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WAIT_W-1:0]  accessWait,
  input  logic [DQ_W-1:0]    dqIn,
  output logic [DEV_CNT-1:0] memCsN,
  output logic               memCke,
  output logic               memCasN,
  output logic [IN_W-1:0]    testVec,
  output logic               memClkEn,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               failValid,
  output logic [DEV_W-1:0]   failDev,
  output logic [VEC_W-1:0]   failVec,
  output logic [DQ_W-1:0]    failMask
);

  seqStrobe_t       strobe;
  logic [DEV_W-1:0] devIdx;
  logic [VEC_W-1:0] vecIdx;
  logic             anyFail;

  bic_ctrl #(
    .DEV_CNT(DEV_CNT), .WAIT_W(WAIT_W), .PAUSE_CYC(PAUSE_CYC), .DEV_W(DEV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .accessWait(accessWait),
    .memCsN(memCsN), .memCke(memCke), .memCasN(memCasN), .memClkEn(memClkEn),
    .busy(busy), .done(done), .strobe(strobe), .devIdx(devIdx), .vecIdx(vecIdx)
  );

  bic_datapath #(.DEV_W(DEV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .devIdx(devIdx), .vecIdx(vecIdx),
    .dqIn(dqIn), .testVec(testVec), .failValid(failValid), .failDev(failDev),
    .failVec(failVec), .failMask(failMask), .anyFail(anyFail)
  );

  assign pass = done && !anyFail;

endmodule

// File: tb/bic_sequencer_bench.sv
module bic_sequencer_bench;

  localparam int DEV   = 3;
  localparam int WW    = 4;
  localparam int PAUSE = 50;
  localparam int NV    = 42;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [WW-1:0] accessWait = '0;
  logic [31:0]   dqIn;
  logic [DEV-1:0] memCsN;
  logic          memCke, memCasN, memClkEn, busy, done, pass, failValid;
  logic [1:0]    failDev;
  logic [5:0]    failVec;
  logic [31:0]   failMask;
  logic [19:0]   testVec;

  int checks = 0;
  int failures = 0;
  int faultMode = 0;
  int waitLim = 0;

  int entries [DEV];
  int exits   [DEV];
  int vecCnt  [DEV];
  bit inTest  [DEV];
  int entryTotal, holdCnt, curDev, pauseCnt, reports;
  logic [19:0] curVec;
  logic prevCas, prevCke;
  logic [DEV-1:0] prevCsN;

  always #5 clk = ~clk;

  bic_sequencer #(.DEV_CNT(DEV), .WAIT_W(WW), .PAUSE_CYC(PAUSE)) u_bic_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .accessWait(accessWait), .dqIn(dqIn),
    .memCsN(memCsN), .memCke(memCke), .memCasN(memCasN), .testVec(testVec),
    .memClkEn(memClkEn), .busy(busy), .done(done), .pass(pass),
    .failValid(failValid), .failDev(failDev), .failVec(failVec), .failMask(failMask)
  );

  function automatic logic [19:0] refStim(input int v);
    if (v < 20)       return 20'd1 << v;
    else if (v < 40)  return ~(20'd1 << (v - 20));
    else if (v == 40) return 20'h00000;
    else              return 20'hFFFFF;
  endfunction

  function automatic logic [31:0] refResp(input logic [19:0] s);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = (s[j % 20] == s[(j + 7) % 20]);
    return r;
  endfunction

  function automatic logic [31:0] devAnswer(input int d, input logic [19:0] s);
    logic [31:0] r;
    r = refResp(s);
    if (faultMode == 1 && d == 1) r[5] = 1'b0;
    if (faultMode == 2 && d == 2) r = '0;
    return r;
  endfunction

  function automatic logic [31:0] refDiff(input int d, input int v);
    return refResp(refStim(v)) ^ devAnswer(d, refStim(v));
  endfunction

  always_comb begin
    dqIn = '0;
    for (int d = 0; d < DEV; d++)
      if (!memCsN[d] && memCke && inTest[d]) dqIn = devAnswer(d, testVec);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int selCnt, selDev;
    bit drivePhase;
    if (!rstN) begin
      for (int d = 0; d < DEV; d++) begin
        entries[d] = 0; exits[d] = 0; vecCnt[d] = 0; inTest[d] = 0;
      end
      entryTotal = 0; holdCnt = 0; curDev = 0; pauseCnt = 0; reports = 0; curVec = '0;
      prevCas = 1'b1; prevCke = 1'b1; prevCsN = '1;
    end else begin
      selCnt = 0; selDev = 0;
      for (int d = 0; d < DEV; d++) if (!memCsN[d]) begin selCnt++; selDev = d; end
      for (int d = 0; d < DEV; d++) begin
        if (!memCsN[d] && !memCke && prevCas && !memCasN) begin
          chk(!prevCke && !prevCsN[d], "R3 setup cycle", {prevCke, prevCsN[d]}, 0);
          chk(d == entryTotal, "R2 device order", d, entryTotal);
          entries[d]++; entryTotal++; inTest[d] = 1;
        end
        if (!memCsN[d] && !memCke && !prevCas && memCasN) begin
          chk(vecCnt[d] == NV, "R8 exit after last vector", vecCnt[d], NV);
          exits[d]++; inTest[d] = 0;
        end
      end
      drivePhase = (selCnt == 1) && memCke && !memCasN;
      if (drivePhase && holdCnt > 0 && selDev == curDev && testVec == curVec) begin
        holdCnt++;
      end else begin
        if (holdCnt > 0) chk(holdCnt == waitLim + 1, "R5 hold length", holdCnt, waitLim + 1);
        holdCnt = 0;
        if (drivePhase) begin
          chk(testVec == refStim(vecCnt[selDev]), "R4 vector order", testVec, refStim(vecCnt[selDev]));
          curDev = selDev; curVec = testVec; vecCnt[selDev]++; holdCnt = 1;
        end
      end
      if (memClkEn && !done) begin
        pauseCnt++;
        chk(&memCsN && memCke && memCasN, "R9 pause pins", {memCsN, memCke, memCasN}, '1);
      end
      if (failValid) begin
        reports++;
        chk(failMask == refDiff(failDev, failVec) && failMask != 0, "R7 R6 fail mask",
            failMask, refDiff(failDev, failVec));
      end
      prevCas = memCasN; prevCke = memCke; prevCsN = memCsN;
    end
  end

  task automatic runOnce(input int mode, input int w, input bit poke);
    int guard, predicted, total;
    faultMode = mode; waitLim = w; accessWait = WW'(w);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(&memCsN && memCke && memCasN && !memClkEn && testVec == 0, "R1 reset pins",
        {memCsN, memCke, memCasN, memClkEn}, {3'b111, 3'b110});
    chk(!busy && !done && !failValid, "R1 reset status", {busy, done, failValid}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    if (!done) chk(0, "watchdog", guard, 0);
    predicted = 0;
    for (int d = 0; d < DEV; d++)
      for (int v = 0; v < NV; v++) if (refDiff(d, v) != 0) predicted++;
    for (int d = 0; d < DEV; d++) begin
      chk(entries[d] == 1 && exits[d] == 1, "R3 R8 R11 one entry/exit", {entries[d], exits[d]}, {32'd1, 32'd1});
      chk(vecCnt[d] == NV, "R4 vector count", vecCnt[d], NV);
    end
    chk(pauseCnt == PAUSE, "R9 pause length", pauseCnt, PAUSE);
    chk(reports == predicted, "R7 report count", reports, predicted);
    chk(pass == (predicted == 0), "R10 pass", pass, predicted == 0);
    total = vecCnt[0] + vecCnt[1] + vecCnt[2];
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk(done && &memCsN && pass == (predicted == 0), "R11 R10 start after done",
          {done, memCsN, pass}, {1'b1, 3'b111, predicted == 0});
    end
    chk(vecCnt[0] + vecCnt[1] + vecCnt[2] == total, "R11 no new vectors",
        vecCnt[0] + vecCnt[1] + vecCnt[2], total);
  endtask

  initial begin
    runOnce(0, 0, 1'b0);
    runOnce(1, 3, 1'b1);
    runOnce(2, 1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule